// File: doc/BRIEF.md
# Modem Status Tracker with Loopback and Status Report

This block watches the four modem input lines of a serial port (clear-to-send, data-set-ready, ring indicator and carrier detect) and keeps an 8-bit modem status byte. The upper nibble gives the current level of each line. The lower nibble holds sticky change flags. A host read strobe clears those flags. A loopback mode, selected by the modem control input, disconnects the pins. In that mode the line levels come from the block's own modem control outputs, so the path can be tested without a cable.

When a change flag newly sets, or when a receive error flag rises, the block queues a two-byte status report on a valid/ready byte stream. The first byte is the modem status byte and the second byte is the line status byte. A trigger that arrives while a report is still in flight is folded into one follow-up report. All line levels are taken as logical "asserted" levels, where 1 means the line is active.

Top module: `modem_status_tracker`

## Requirements
- R1: `msr_o` bit 4 reports CTS, bit 5 DSR, bit 6 RI and bit 7 DCD. In normal mode a pin change appears there on the third rising clock edge after the pin changes: two synchroniser stages, then the level register.
- R2: `msr_o` bits 0 (CTS), 1 (DSR) and 3 (DCD) are set when the level of that line changes in either direction. Each bit stays set until a read strobe clears it.
- R3: `msr_o` bit 2 is set only when the RI level goes from 1 to 0, which is the end of a ring. RI going from 0 to 1 leaves bit 2 unchanged.
- R4: A cycle with `rd_stb_i` high clears bits 3:0 at the next edge. If a line change is detected at that same edge, its flag is still set afterwards.
- R5: When `mcr_i[4]` is 1, the line levels become CTS=`mcr_i[1]`, DSR=`mcr_i[0]`, RI=`mcr_i[2]` and DCD=`mcr_i[3]`, one edge after `mcr_i` is sampled. The pins are ignored while this mode is active.
- R6: Entering or leaving loopback sets the change flags of every line whose level moves, under the same rules as R2 and R3.
- R7: A report starts on the edge where a change flag goes from 0 to 1, or where any of `line_st_i[4:1]` rises. From that edge `rpt_valid_o` is high and the first byte equals the `msr_o` value of that same cycle, with `rpt_last_o` low.
- R8: The second byte has `rpt_last_o` high. It equals `line_st_i[6:0]` as sampled at the start edge, with bit 7 set to the OR of bits 2 (parity), 3 (framing) and 4 (break). Bit 0 is data ready, bit 1 overrun, bit 5 holding-register empty and bit 6 transmitter empty.
- R9: While `rpt_valid_o` is high and `rpt_ready_i` is low, `rpt_data_o` and `rpt_last_o` hold their values. A byte is taken on an edge where both `rpt_valid_o` and `rpt_ready_i` are high.
- R10: Any number of triggers during an in-flight report lead to exactly one further report. That report starts on the edge where the second byte is taken, and it carries the values sampled at that edge.
- R11: After reset, `msr_o` is 0 and `rpt_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_i | input | 1 | Clear-to-send level, asynchronous |
| dsr_i | input | 1 | Data-set-ready level, asynchronous |
| ri_i | input | 1 | Ring indicator level, asynchronous |
| dcd_i | input | 1 | Carrier detect level, asynchronous |
| mcr_i | input | 5 | Modem control: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback |
| line_st_i | input | 7 | Line status flags, synchronous (bit map in R8) |
| rd_stb_i | input | 1 | Host read of the status byte; clears change flags |
| msr_o | output | 8 | Modem status byte |
| rpt_valid_o | output | 1 | Report byte valid |
| rpt_ready_i | input | 1 | Report byte accepted |
| rpt_data_o | output | 8 | Report byte |
| rpt_last_o | output | 1 | Second (line status) byte of a report |

## Verification
The bound checker tests these properties on every cycle:
- the report byte stays stable under backpressure;
- the first byte of a new report matches the live status byte;
- the error summary bit of the second byte is consistent with the bits it combines;
- sticky change flags are only cleared by a read;
- the RI change flag rises only together with a falling RI level;
- in loopback, the levels equal the control bits of the previous cycle.

Some behaviour only the bench scenarios can show, compared against a behavioural reference model:
- the three-edge pin latency;
- the read and change collision;
- the folding of several triggers into one follow-up report;
- the pins being ignored in loopback.

// File: rtl/mst_pkg.sv
package mst_pkg;

  // line index inside the internal level vector (matches status bit order)
  localparam int LINE_CNT = 4;
  localparam int IDX_CTS  = 0;
  localparam int IDX_DSR  = 1;
  localparam int IDX_RI   = 2;
  localparam int IDX_DCD  = 3;

  // control bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;
  localparam int CTL_W    = 5;

  // line status layout
  localparam int LST_W    = 7;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {
    RPT_IDLE = 2'd0,
    RPT_MSR  = 2'd1,
    RPT_LSR  = 2'd2
  } rpt_state_e;

endpackage

// File: rtl/mst_sync.sv
module mst_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/mst_delta.sv
module mst_delta #(
  parameter int         W          = 4,
  parameter logic [W-1:0] TRAIL_MASK = 4'b0100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic         clr_i,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] dlt_q,
  output logic [W-1:0] lvl_d,
  output logic [W-1:0] dlt_d,
  output logic         new_flag_o
);

  logic [W-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_line
      if (TRAIL_MASK[i]) begin : g_trail
        assign hit[i] = lvl_q[i] & ~level_i[i];
      end else begin : g_both
        assign hit[i] = lvl_q[i] ^ level_i[i];
      end
    end
  endgenerate

  always_comb begin
    lvl_d      = level_i;
    dlt_d      = (clr_i ? '0 : dlt_q) | hit;
    new_flag_o = |(dlt_d & ~dlt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dlt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      dlt_q <= dlt_d;
    end
  end

endmodule

// File: rtl/mst_report.sv
module mst_report
  import mst_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [BW-1:0] msr_next_i,
  input  logic [BW-1:0] lsr_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [BW-1:0] data_o,
  output logic          last_o
);

  rpt_state_e    state_q, state_d;
  logic          pend_q, pend_d;
  logic          load;
  logic [BW-1:0] smsr_q, slsr_q;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    load    = 1'b0;
    unique case (state_q)
      RPT_IDLE: begin
        if (trig_i) begin
          state_d = RPT_MSR;
          load    = 1'b1;
        end
      end
      RPT_MSR: begin
        pend_d = pend_q | trig_i;
        if (ready_i) state_d = RPT_LSR;
      end
      RPT_LSR: begin
        if (ready_i) begin
          if (trig_i || pend_q) begin
            state_d = RPT_MSR;
            load    = 1'b1;
            pend_d  = 1'b0;
          end else begin
            state_d = RPT_IDLE;
          end
        end else begin
          pend_d = pend_q | trig_i;
        end
      end
      default: state_d = RPT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RPT_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  // snapshot registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smsr_q <= '0;
      slsr_q <= '0;
    end else if (load) begin
      smsr_q <= msr_next_i;
      slsr_q <= lsr_i;
    end
  end

  assign valid_o = (state_q != RPT_IDLE);
  assign last_o  = (state_q == RPT_LSR);
  assign data_o  = last_o ? slsr_q : smsr_q;

endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import mst_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [LINE_CNT-1:0] TRAIL_MASK  = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  input  logic [CTL_W-1:0]  mcr_i,
  input  logic [LST_W-1:0]  line_st_i,
  input  logic              rd_stb_i,
  output logic [BYTE_W-1:0] msr_o,
  output logic              rpt_valid_o,
  input  logic              rpt_ready_i,
  output logic [BYTE_W-1:0] rpt_data_o,
  output logic              rpt_last_o
);

  localparam int ERR_LO = 1;
  localparam int ERR_HI = 4;
  localparam int ERR_W  = ERR_HI - ERR_LO + 1;

  logic [LINE_CNT-1:0] pins, pins_s, loop_lv, level;
  logic [LINE_CNT-1:0] lvl_q, dlt_q, lvl_d, dlt_d;
  logic                dlt_new;
  logic [ERR_W-1:0]    err_prev_q;
  logic                err_rise;
  logic [BYTE_W-1:0]   lsr;

  always_comb begin
    pins          = '0;
    pins[IDX_CTS] = cts_i;
    pins[IDX_DSR] = dsr_i;
    pins[IDX_RI]  = ri_i;
    pins[IDX_DCD] = dcd_i;
    loop_lv          = '0;
    loop_lv[IDX_CTS] = mcr_i[CTL_RTS];
    loop_lv[IDX_DSR] = mcr_i[CTL_DTR];
    loop_lv[IDX_RI]  = mcr_i[CTL_OUT1];
    loop_lv[IDX_DCD] = mcr_i[CTL_OUT2];
  end

  mst_sync #(.W(LINE_CNT), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins),
    .sync_o  (pins_s)
  );

  assign level = mcr_i[CTL_LOOP] ? loop_lv : pins_s;

  mst_delta #(.W(LINE_CNT), .TRAIL_MASK(TRAIL_MASK)) i_delta (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (level),
    .clr_i      (rd_stb_i),
    .lvl_q      (lvl_q),
    .dlt_q      (dlt_q),
    .lvl_d      (lvl_d),
    .dlt_d      (dlt_d),
    .new_flag_o (dlt_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_prev_q <= '0;
    else        err_prev_q <= line_st_i[ERR_HI:ERR_LO];
  end

  assign err_rise = |(line_st_i[ERR_HI:ERR_LO] & ~err_prev_q);
  assign lsr      = {|line_st_i[4:2], line_st_i};

  mst_report #(.BW(BYTE_W)) i_report (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (dlt_new | err_rise),
    .msr_next_i ({lvl_d, dlt_d}),
    .lsr_i      (lsr),
    .valid_o    (rpt_valid_o),
    .ready_i    (rpt_ready_i),
    .data_o     (rpt_data_o),
    .last_o     (rpt_last_o)
  );

  assign msr_o = {lvl_q, dlt_q};

endmodule

// File: rtl/mst_checker.sv
module mst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb_i,
  input logic [4:0] mcr_i,
  input logic [7:0] msr_o,
  input logic       rpt_valid_o,
  input logic       rpt_ready_i,
  input logic [7:0] rpt_data_o,
  input logic       rpt_last_o
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(rd_stb_i) |-> ((msr_o[3:0] & $past(msr_o[3:0])) == $past(msr_o[3:0])));

  assert_ri_trailing_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(msr_o[2]) |-> $fell(msr_o[6]));

  assert_loop_map_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(mcr_i[4]) |-> (msr_o[7:4] ==
      {$past(mcr_i[3]), $past(mcr_i[2]), $past(mcr_i[0]), $past(mcr_i[1])}));

  assert_first_byte_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(rpt_valid_o) |-> (rpt_data_o == msr_o && !rpt_last_o));

  assert_err_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && rpt_last_o) |-> (rpt_data_o[7] == |rpt_data_o[4:2]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && !rpt_ready_i) |=>
      (rpt_valid_o && $stable(rpt_data_o) && $stable(rpt_last_o)));

  assert_last_in_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_last_o |-> rpt_valid_o);

endmodule

bind modem_status_tracker mst_checker i_mst_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_stb_i    (rd_stb_i),
  .mcr_i       (mcr_i),
  .msr_o       (msr_o),
  .rpt_valid_o (rpt_valid_o),
  .rpt_ready_i (rpt_ready_i),
  .rpt_data_o  (rpt_data_o),
  .rpt_last_o  (rpt_last_o)
);

// File: tb/test_modem_status_tracker.sv
`timescale 1ns/1ps
module test_modem_status_tracker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cts, dsr, ri, dcd;
  logic [4:0] mcr;
  logic [6:0] line_st;
  logic       rd_stb;
  logic [7:0] msr_o;
  logic       rpt_valid, rpt_ready, rpt_last;
  logic [7:0] rpt_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  modem_status_tracker i_modem_status_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_i       (cts),
    .dsr_i       (dsr),
    .ri_i        (ri),
    .dcd_i       (dcd),
    .mcr_i       (mcr),
    .line_st_i   (line_st),
    .rd_stb_i    (rd_stb),
    .msr_o       (msr_o),
    .rpt_valid_o (rpt_valid),
    .rpt_ready_i (rpt_ready),
    .rpt_data_o  (rpt_data),
    .rpt_last_o  (rpt_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [3:0] m_s1, m_s2, m_lvl, m_dlt, m_eprev;
  int       m_state;      // 0 idle, 1 first byte, 2 second byte
  bit       m_pend;
  bit [7:0] m_smsr, m_slsr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_dlt = 0; m_eprev = 0;
      m_state = 0; m_pend = 0; m_smsr = 0; m_slsr = 0;
    end else begin
      bit [3:0] src, hit, nd;
      bit       trig;
      bit [7:0] lsrv;
      src = mcr[4] ? {mcr[3], mcr[2], mcr[0], mcr[1]} : m_s2;
      for (int i = 0; i < 4; i++)
        hit[i] = (i == 2) ? (m_lvl[i] && !src[i]) : (m_lvl[i] != src[i]);
      nd   = (rd_stb ? 4'b0 : m_dlt) | hit;
      trig = ((nd & ~m_dlt) != 0) || ((line_st[4:1] & ~m_eprev) != 0);
      lsrv = {(line_st[4:2] != 0), line_st};
      if (m_state == 0) begin
        if (trig) begin m_state = 1; m_smsr = {src, nd}; m_slsr = lsrv; end
      end else if (m_state == 1) begin
        m_pend = m_pend | trig;
        if (rpt_ready) m_state = 2;
      end else begin
        if (rpt_ready) begin
          if (trig || m_pend) begin
            m_state = 1; m_smsr = {src, nd}; m_slsr = lsrv; m_pend = 0;
          end else m_state = 0;
        end else m_pend = m_pend | trig;
      end
      m_s2 = m_s1; m_s1 = {dcd, ri, dsr, cts};
      m_lvl = src; m_dlt = nd; m_eprev = line_st[4:1];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(msr_o == {m_lvl, m_dlt}, "R1 model msr_o", msr_o, {m_lvl, m_dlt});
      chk(rpt_valid == (m_state != 0), "R7 model valid", rpt_valid, m_state != 0);
      if (m_state != 0) begin
        chk(rpt_data == ((m_state == 1) ? m_smsr : m_slsr), "R9 model data", rpt_data,
            (m_state == 1) ? m_smsr : m_slsr);
        chk(rpt_last == (m_state == 2), "R9 model last", rpt_last, m_state == 2);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic pulse_rd();
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cts = 0; dsr = 0; ri = 0; dcd = 0;
    mcr = 5'h00; line_st = 7'h00; rd_stb = 0; rpt_ready = 1'b1;
    tick(3);
    rst_n = 1'b1;
    chk(msr_o == 8'h00 && !rpt_valid, "R11 reset state", msr_o, 0);

    // CTS rises: three edges to reach the status byte
    cts = 1'b1;
    tick(2);
    chk(msr_o[4] == 1'b0, "R1 not before third edge", msr_o, 8'h00);
    tick();
    chk(msr_o == 8'h11, "R1 R2 CTS level and flag", msr_o, 8'h11);
    pulse_rd();
    chk(msr_o == 8'h10, "R4 read clears flags", msr_o, 8'h10);

    // RI rising edge: no flag; RI falling edge: flag
    ri = 1'b1;
    tick(3);
    chk(msr_o == 8'h50, "R3 RI rise sets no flag", msr_o, 8'h50);
    ri = 1'b0;
    tick(3);
    chk(msr_o == 8'h14, "R3 RI trailing edge flag", msr_o, 8'h14);
    pulse_rd();

    // DSR change detected on the same edge as a read
    dsr = 1'b1;
    tick(2);
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
    chk(msr_o == 8'h32, "R4 change kept during read", msr_o, 8'h32);
    pulse_rd();
    chk(msr_o == 8'h30, "R2 flag cleared only by read", msr_o, 8'h30);

    // loopback: RTS and OUT2 driven, DTR and OUT1 low
    mcr = 5'h1A;
    tick();
    chk(msr_o == 8'h9A, "R5 R6 loopback map and flags", msr_o, 8'h9A);
    {dcd, ri, dsr, cts} = 4'b0000;
    tick(4);
    chk(msr_o == 8'h9A, "R5 pins ignored in loopback", msr_o, 8'h9A);
    {dcd, ri, dsr, cts} = 4'b1111;
    tick(3);
    pulse_rd();
    mcr = 5'h00;
    tick();
    chk(msr_o == 8'hF2, "R6 leaving loopback flags", msr_o, 8'hF2);
    tick(5);

    // error rise with backpressure, then a merged second trigger
    rpt_ready = 1'b0;
    line_st = 7'h62;
    tick();
    chk(rpt_valid && !rpt_last && rpt_data == 8'hF2, "R7 report first byte", rpt_data, 8'hF2);
    line_st = 7'h66;
    tick();
    line_st = 7'h6E;
    tick();
    chk(rpt_valid && rpt_data == 8'hF2 && !rpt_last, "R9 held under backpressure", rpt_data, 8'hF2);
    rpt_ready = 1'b1;
    tick();
    chk(rpt_valid && rpt_last && rpt_data == 8'h62, "R8 second byte no error", rpt_data, 8'h62);
    tick();
    chk(rpt_valid && !rpt_last && rpt_data == 8'hF2, "R10 one follow-up report", rpt_data, 8'hF2);
    tick();
    chk(rpt_valid && rpt_last && rpt_data == 8'hEE, "R8 error summary bit", rpt_data, 8'hEE);
    tick();
    chk(!rpt_valid, "R10 no extra report", rpt_valid, 0);
    tick(3);
    chk(!rpt_valid, "R7 steady flags start nothing", rpt_valid, 0);

    // DCD change while ready is low and several triggers
    rpt_ready = 1'b0;
    dcd = 1'b0;
    tick(3);
    chk(rpt_valid && rpt_data == msr_o, "R7 DCD change report", rpt_data, msr_o);
    chk(msr_o[3] == 1'b1, "R2 DCD falling flag", msr_o, 8'h08);
    line_st = 7'h00;
    tick();
    line_st = 7'h02;
    tick();
    rpt_ready = 1'b1;
    tick(6);
    chk(!rpt_valid, "R10 queue drained", rpt_valid, 0);

    tick(2);
    finish_run();
  end

endmodule